// File: doc/BRIEF.md
# Two-Wire Register File Slave

This block is a slave on a two-wire serial bus that gives a bus master read and write access to a 64-byte register space. It samples the clock and data lines on the system clock through a short synchronizer and detects start and stop conditions. It then decodes a fixed device address byte and acknowledges each byte it accepts. Its only bus output is an open-drain pull-down enable for the data line. In the register space the eight lowest locations hold the clock/calendar fields (seconds, minutes, hours, weekday, day of month, month, year, control) and the other 56 are general storage. The slave has no special handling for the calendar locations.

A write transfer carries a word-address byte that loads an internal pointer, followed by any number of data bytes. A read transfer returns bytes starting from wherever the pointer currently stands. The pointer steps by one after every data byte in either direction and wraps at the top of the map. A power-fail input forces the slave off the bus: the transfer in progress is dropped, the pointer goes back to zero and the bus lines are not looked at until the input is released.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset the data-line pull-down is off and the pointer is 0. Stored bytes are not cleared by reset, so a read issued right after reset returns location 0.
- R2: Only the address byte 0xD0 (write) or 0xD1 (read) is acknowledged. Any other address byte gets no acknowledge, and the slave neither drives the line nor changes the pointer or storage until the next start condition.
- R3: The slave acknowledges a matched address byte, the word-address byte and each written data byte by pulling the data line low during the ninth clock pulse. The pull-down enable changes only while the synchronized clock line is low.
- R4: In a write, the low 6 bits of the first byte after the address load the pointer and its upper 2 bits are ignored. Each later byte is stored at the pointer, and then the pointer advances by one.
- R5: A read sends the byte at the current pointer, most significant bit first, and advances the pointer by one per byte. A master acknowledge (data low on the ninth pulse) continues with the next byte. A master non-acknowledge ends the read: the slave stays off the line and leaves the pointer alone until the next start.
- R6: The pointer wraps from 63 to 0 on reads and on writes.
- R7: While power-fail is high, the pull-down is released within one cycle, the pointer returns to 0, and bus activity (including start conditions and address bytes) is ignored.
- R8: A data change while the clock is high is a condition: falling data is a start, and rising data is a stop. A stop returns the slave to idle, so bytes clocked after it without a start get no acknowledge. A repeated start begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| pwr_fail | input | 1 | Supply out of tolerance; high aborts and silences the slave |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
A wrong pointer shows up as wrong read data. Once a master reads at a known location, that wrong byte appears within the first eight clock pulses of the read. A stuck or wrong protocol state shows up at the ninth pulse of the next byte as a missing or unwanted acknowledge, or as the data line being driven while it should be released. Faults in the power-fail path show up as an acknowledge given while power-fail is high, or as a read after release that does not start at location 0. Wrap faults can only be seen in transfers that cross location 63, so those are driven on purpose.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire register file slave.
// Assumes: one protocol state machine instance per slave.
package twi_pkg;

    // Protocol phases of the slave
    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for a start condition
        ST_DEVADDR,   // shifting in the device address byte
        ST_ACK_DEV,   // driving acknowledge for the device address
        ST_WORDADDR,  // shifting in the word-address byte
        ST_ACK_RX,    // driving acknowledge for a received byte
        ST_WDATA,     // shifting in a write data byte
        ST_RDATA,     // shifting out a read data byte
        ST_RACK,      // sampling the master's acknowledge after a read byte
        ST_IGNORE     // off the bus until the next start or stop
    } twi_state_e;

endpackage

// File: rtl/twi_line_monitor.sv
// Synchronizes the bus clock and data lines to the system clock and
// derives clock edges plus start and stop conditions.
// Assumes: SYNC_STAGES >= 2; both lines idle high; the system clock is
// several times faster than the bus clock so each bus phase spans
// multiple samples.
module twi_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LANES = 2;  // lane 0 = clock, lane 1 = data

    logic [LANES-1:0] raw_w;
    logic [LANES-1:0] lvl_w;
    logic [LANES-1:0] prv_w;

    assign raw_w = {sda_raw, scl_raw};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   prev_q;

        // Shift the raw line through the synchronizer and keep the previous sample
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-2:0], raw_w[g]};
                prev_q  <= chain_q[SYNC_STAGES-1];
            end
        end

        assign lvl_w[g] = chain_q[SYNC_STAGES-1];
        assign prv_w[g] = prev_q;
    end

    // Decode edges and bus conditions from current and previous samples
    always_comb begin
        scl_level = lvl_w[0];
        sda_level = lvl_w[1];
        scl_rise  = lvl_w[0] & ~prv_w[0];
        scl_fall  = ~lvl_w[0] & prv_w[0];
        start_det = lvl_w[0] & prv_w[0] & prv_w[1] & ~lvl_w[1];
        stop_det  = lvl_w[0] & prv_w[0] & ~prv_w[1] & lvl_w[1];
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall})); // R8

endmodule

// File: rtl/twi_byte_store.sv
// Byte-wide register storage: one synchronous write port and one
// combinational read port. Contents are not cleared by reset.
// Assumes: write and read addresses are always in range (DEPTH a power of 2).
module twi_byte_store #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // Store one byte per write strobe
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/twi_slave_fsm.sv
// Protocol engine of the slave: address match, word-address load,
// byte receive and transmit, acknowledge handling and the address pointer.
// Assumes: events come from twi_line_monitor (single-cycle pulses);
// pwr_fail is synchronous to clk; no clock stretching.
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          AW       = 6,
    parameter logic [DW-2:0] DEV_ADDR = 7'h68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_fail,
    input  logic          scl_level,
    input  logic          sda_level,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] ptr
);

    localparam int          CW   = $clog2(DW + 1);
    localparam logic [CW-1:0] BITS = CW'(DW);
    localparam logic [AW-1:0] ONE  = AW'(1);

    twi_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q,   cnt_d;
    logic [DW-1:0] shift_q, shift_d;
    logic [DW-1:0] tx_q,    tx_d;
    logic          rw_q,    rw_d;
    logic          more_q,  more_d;
    logic [AW-1:0] ptr_q,   ptr_d;
    logic          oe_q,    oe_d;
    logic          wr_d;

    // Compute next protocol state, pointer and line drive from bus events
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        tx_d    = tx_q;
        rw_d    = rw_q;
        more_d  = more_q;
        ptr_d   = ptr_q;
        oe_d    = oe_q;
        wr_d    = 1'b0;
        if (pwr_fail) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            ptr_d   = '0;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_DEVADDR, ST_WORDADDR, ST_WDATA: begin
                    if (scl_rise && cnt_q != BITS) begin
                        shift_d = {shift_q[DW-2:0], sda_level};
                        cnt_d   = cnt_q + 1'b1;
                    end
                    if (scl_fall && cnt_q == BITS) begin
                        cnt_d = '0;
                        if (state_q == ST_DEVADDR) begin
                            if (shift_q[DW-1:1] == DEV_ADDR) begin
                                oe_d    = 1'b1;
                                rw_d    = shift_q[0];
                                state_d = ST_ACK_DEV;
                            end else begin
                                state_d = ST_IGNORE;
                            end
                        end else if (state_q == ST_WORDADDR) begin
                            ptr_d   = shift_q[AW-1:0];
                            oe_d    = 1'b1;
                            state_d = ST_ACK_RX;
                        end else begin
                            wr_d    = 1'b1;
                            ptr_d   = ptr_q + 1'b1;
                            oe_d    = 1'b1;
                            state_d = ST_ACK_RX;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            tx_d    = rd_data;
                            oe_d    = ~rd_data[DW-1];
                            state_d = ST_RDATA;
                        end else begin
                            oe_d    = 1'b0;
                            state_d = ST_WORDADDR;
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && cnt_q != BITS) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                    if (scl_fall) begin
                        if (cnt_q == BITS) begin
                            oe_d    = 1'b0;
                            ptr_d   = ptr_q + 1'b1;
                            state_d = ST_RACK;
                        end else begin
                            tx_d = {tx_q[DW-2:0], 1'b0};
                            oe_d = ~tx_q[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        more_d = ~sda_level;
                    end
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (more_q) begin
                            tx_d    = rd_data;
                            oe_d    = ~rd_data[DW-1];
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // Register protocol state, pointer and data-line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            more_q  <= 1'b0;
            ptr_q   <= '0;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            tx_q    <= tx_d;
            rw_q    <= rw_d;
            more_q  <= more_d;
            ptr_q   <= ptr_d;
            oe_q    <= oe_d;
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_d;
    assign wr_data = shift_q;
    assign ptr     = ptr_q;

    AST_PF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !oe_q); // R7
    AST_PF_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ptr_q == '0)); // R7
    AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !oe_q); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && state_q != ST_WORDADDR) |=>
        (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + ONE)); // R4
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail && !start_det && !stop_det && scl_level) |=> $stable(oe_q)); // R3
    AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> oe_q); // R3

endmodule

// File: rtl/twi_regfile_slave.sv
// Top of the two-wire register file slave: line monitor, protocol
// engine and 64-byte storage. The data pad is open drain: sda_oe = 1
// pulls it low. Assumes the pad returns the wired bus level on sda_i.
module twi_regfile_slave #(
    parameter int            DEPTH       = 64,
    parameter int            DW          = 8,
    parameter logic [DW-2:0] DEV_ADDR    = 7'h68,
    parameter int            SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pwr_fail,
    output logic sda_oe
);

    localparam int AW = $clog2(DEPTH);

    logic          scl_level, sda_level, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [DW-1:0] wr_data, rd_data;
    logic [AW-1:0] ptr;

    twi_line_monitor #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_level(scl_level),
        .sda_level(sda_level),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_slave_fsm #(
        .DW      (DW),
        .AW      (AW),
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .scl_level(scl_level),
        .sda_level(sda_level),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr      (ptr)
    );

    twi_byte_store #(
        .DEPTH(DEPTH),
        .DW   (DW)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(ptr),
        .wr_data(wr_data),
        .rd_addr(ptr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/tb_twi_regfile_slave.sv
// Self-checking bench: a bus master model drives the clock and data lines,
// a byte model of the register space predicts every read and acknowledge.
module tb_twi_regfile_slave;

    localparam int Q  = 6;        // system clocks per quarter bus bit
    localparam int WD = 190000;   // watchdog limit in clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit [7:0] model [64];
    int       mptr = 0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    twi_regfile_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .pwr_fail(pwr_fail),
        .sda_oe  (sda_oe)
    );

    function automatic bit [7:0] exp_byte(input int a);
        return model[a & 63];
    endfunction

    function automatic int next_ptr(input int a);
        return (a + 1) & 63;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_byte(input bit [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_q();
            wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        acked = !sda_bus;
        wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input bit give_ack, output bit [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wait_q();
            m_scl = 1'b1; wait_q();
            b[i] = sda_bus;
            wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    // Write: address 0xD0, word byte, n random data bytes
    task automatic do_write(input bit [7:0] word, input int n, input string req);
        bit ack;
        bit [7:0] d;
        bus_start();
        send_byte(8'hD0, ack); chk(ack, "R3 write address ack", ack, 1);
        send_byte(word, ack);  chk(ack, "R3 word byte ack", ack, 1);
        mptr = word & 63;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            chk(ack, req, ack, 1);
            model[mptr] = d;
            mptr = next_ptr(mptr);
        end
        bus_stop();
    endtask

    // Read n bytes from the current pointer after a start or repeated start
    task automatic read_bytes(input int n, input string req);
        bit ack;
        bit [7:0] d;
        send_byte(8'hD1, ack); chk(ack, "R8 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(d == exp_byte(mptr), req, d, exp_byte(mptr));
            mptr = next_ptr(mptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, input string req);
        bus_start();
        read_bytes(n, req);
    endtask

    task automatic seek_read(input bit [7:0] word, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(8'hD0, ack); chk(ack, "R3 write address ack", ack, 1);
        send_byte(word, ack);  chk(ack, "R4 word byte ack", ack, 1);
        mptr = word & 63;
        bus_start();
        read_bytes(n, req);
    endtask

    initial begin
        bit ack;
        bit [7:0] d;
        void'($urandom(32'd5171));
        repeat (4) @(posedge clk);
        #2;
        chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
        rst_n = 1'b1;
        wait_q();
        chk(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);

        // Fill the whole map; the burst ends with the pointer wrapped to 0
        do_write(8'h00, 64, "R3 data ack fill");

        // Reset keeps storage and clears the pointer
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        mptr = 0;
        do_read(1, "R1 read after reset");

        // Random bursts; word bytes carry random upper bits (R4)
        for (int it = 0; it < 12; it++) begin
            do_write(8'($urandom), 1 + int'($urandom % 4), "R4 burst ack");
            seek_read(8'($urandom), 1 + int'($urandom % 4), "R4 R5 readback");
            if (it % 4 == 0) do_read(2, "R5 current read");
        end

        // Wrap on write and read (R6)
        do_write(8'd62, 4, "R6 write wrap ack");
        seek_read(8'd63, 3, "R6 read wrap");
        seek_read(8'd62, 4, "R6 write wrap data");

        // Foreign addresses are not acknowledged (R2)
        bus_start();
        send_byte(8'hA0, ack); chk(!ack, "R2 foreign address", ack, 0);
        send_byte(8'h03, ack); chk(!ack, "R2 ignored word byte", ack, 0);
        send_byte(8'h77, ack); chk(!ack, "R2 ignored data byte", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD2, ack); chk(!ack, "R2 near-miss address", ack, 0);
        bus_stop();
        do_read(1, "R2 pointer and data unchanged");

        // Master NACK ends the read (R5)
        bus_start();
        send_byte(8'hD1, ack); chk(ack, "R5 read address ack", ack, 1);
        recv_byte(1'b0, d);
        chk(d == exp_byte(mptr), "R5 last byte", d, exp_byte(mptr));
        mptr = next_ptr(mptr);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R5 silent after NACK", d, 8'hFF);
        bus_stop();
        do_read(1, "R5 pointer held after NACK");

        // Stop returns to idle: no start, no acknowledge (R8)
        send_byte(8'hD0, ack); chk(!ack, "R8 byte without start", ack, 0);
        bus_stop();

        // Power fail during an acknowledge (R7)
        bus_start();
        send_byte(8'hD0, ack); chk(ack, "R3 write address ack", ack, 1);
        send_byte(8'd11, ack); chk(ack, "R4 word byte ack", ack, 1);
        d = 8'($urandom);
        for (int i = 7; i >= 0; i--) begin
            m_sda = d[i]; wait_q();
            m_scl = 1'b1; wait_q();
            wait_q();
            m_scl = 1'b0; wait_q();
        end
        model[11] = d;
        m_sda = 1'b1; wait_q();
        chk(sda_oe == 1'b1, "R3 ack before power fail", sda_oe, 1);
        pwr_fail = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        chk(sda_oe == 1'b0, "R7 release on power fail", sda_oe, 0);
        bus_start();
        send_byte(8'hD0, ack); chk(!ack, "R7 address ignored", ack, 0);
        send_byte(8'd20, ack); chk(!ack, "R7 word ignored", ack, 0);
        send_byte(8'h5A, ack); chk(!ack, "R7 data ignored", ack, 0);
        bus_stop();
        pwr_fail = 1'b0;
        wait_q();
        mptr = 0;
        do_read(1, "R7 pointer back to zero");
        seek_read(8'd20, 1, "R7 storage untouched");
        seek_read(8'd11, 1, "R7 byte before failure kept");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule